// File: doc/BRIEF.md
# DMA Global Control Block

This block is the shared register bank that sits in front of a group of DMA channels. It owns the controller enable, two sticky summary flags (one for address faults, one for halts reported by any channel), a per-channel interrupt-pending word, a per-channel doorbell word and a per-channel clock-enable word. Every channel reports three kinds of event: the end of a descriptor chain (with that chain's interrupt-request flag), a halt and an address fault. The block folds these events into the pending word and drives one interrupt line toward the processor.

Software reaches the block over a simple 32-bit register bus. The bus carries a write strobe, a byte address and write data, and read data follows the address combinationally. When the top address bit is set, the access goes to the global registers. Otherwise the address falls into one of the channel windows, each 0x20 bytes wide and indexed by channel number. For a window access the block raises a one-hot channel select, gives the word offset inside the window, and returns that channel's read data. The channel datapaths are outside the block.

Top module: `dma_global_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control, pending, doorbell and clock-enable registers read zero. The interrupt, doorbell request and clock-enable outputs are low.
- R2: Control register (global offset 0x00): bit 0 is the controller enable and can be read and written. Bit 2 is the address-fault summary and bit 3 is the halt summary. All other bits read zero, and writing a one to bit 2 or bit 3 never sets that bit.
- R3: An address fault on any channel sets control bit 2, and a halt on any channel sets control bit 3. Each flag stays set until a control write carries a zero in its position. When an event and such a write arrive in the same cycle, the flag stays set.
- R4: A channel's pending bit (offset 0x04, bit n for channel n) is set in the cycle after a chain end that has the interrupt request set, a halt or an address fault. A chain end without the interrupt request does not set the bit.
- R5: A write to offset 0x04 keeps only the pending bits written as one and clears the rest. A new event for a channel in the same cycle leaves that channel's bit set.
- R6: The interrupt output is high exactly when the controller enable is set and at least one pending bit is set.
- R7: Doorbell (offset 0x08, bit n for channel n) drives the per-channel request outputs. A write to 0x08 loads the word. Ones written to offset 0x0C set bits, and zero bits have no effect. A channel acknowledge clears its bit, but a set in the same cycle wins over the acknowledge.
- R8: Clock enable (offset 0x10) drives the per-channel clock-enable outputs. A write to 0x10 loads the word. Ones written to 0x14 set bits and ones written to 0x18 clear bits. Zero bits in either alias have no effect.
- R9: With the top address bit clear, address bits [ADDR_W-2:5] pick a channel window of 0x20 bytes. That channel's select is raised (one-hot), the word offset is address bits [4:2], and read data comes from that channel. A window whose index is at or above the channel count selects nothing and reads zero.
- R10: In the global region, the set and clear aliases (0x0C, 0x14, 0x18), unused offsets and any address with nonzero bits [ADDR_W-2:5] read zero. Writes to unused offsets and to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| chan_sel | output | NCH | One-hot select of the addressed channel window |
| chan_wr | output | 1 | Write strobe toward the channel windows |
| chan_off | output | 3 | Word offset inside the channel window |
| chan_rdata | input | NCH*32 | Read data from every channel, channel n at bits [32n+31:32n] |
| ev_term | input | NCH | Per-channel chain-end event |
| ev_tie | input | NCH | Interrupt request of the ending chain, qualifies ev_term |
| ev_halt | input | NCH | Per-channel halt event |
| ev_aerr | input | NCH | Per-channel address-fault event |
| db_ack | input | NCH | Channel acknowledges its doorbell |
| db_req | output | NCH | Doorbell request per channel |
| ch_clk_en | output | NCH | Clock enable per channel |
| irq | output | 1 | Interrupt to the processor |

## Verification
Every cycle, the assertions check that a qualifying channel event lands in its pending bit and that a pending bit falls only through a pending write that omits it. They also check that the summary flags hold until a control write clears them, that the interrupt follows the enable and any new event, that set and clear aliases land in the next cycle, and that the channel select stays one-hot. Some properties are only visible in the bench's scenarios. These are the exact read value of each register under mixed traffic, the priority of an event over a write-back clear in the same cycle, and a set winning over a doorbell acknowledge. They also include the zero reads and inert writes of unmapped global addresses and the decoding of window indices above the channel count.

// File: rtl/dma_gc_pkg.sv
// Package: shared definitions for the DMA global control block.
// Holds the word indices of the global registers and the control bit positions.
// Assumes 32-bit registers with word-aligned byte addresses.
package dma_gc_pkg;

    localparam int DATA_W   = 32;
    localparam int GREG_NUM = 8;

    // Word index (address bits [4:2]) of each global register.
    typedef enum logic [2:0] {
        GREG_CTRL      = 3'd0,
        GREG_PEND      = 3'd1,
        GREG_DOOR      = 3'd2,
        GREG_DOOR_SET  = 3'd3,
        GREG_CKEN      = 3'd4,
        GREG_CKEN_SET  = 3'd5,
        GREG_CKEN_CLR  = 3'd6,
        GREG_SPARE     = 3'd7
    } greg_e;

    // Bit positions inside the control register.
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_AERR_BIT = 2;
    localparam int CTRL_HALT_BIT = 3;

endpackage

// File: rtl/dma_gc_decode.sv
// Module: address decoder for the DMA global control block.
// Splits the bus address into the global region (top bit set, window index 0)
// and the channel windows (top bit clear). Each channel window is 0x20 bytes,
// and the window index is address bits [ADDR_W-2:5].
// Assumes ADDR_W >= 7 and that NCH fits in the window index range.
module dma_gc_decode
    import dma_gc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    output logic                glob_hit,
    output logic [2:0]          glob_word,
    output logic [GREG_NUM-1:0] greg_we,
    output logic [NCH-1:0]      chan_sel,
    output logic                chan_wr,
    output logic [2:0]          chan_off
);

    localparam int CIW = ADDR_W - 6;

    logic            in_glob;
    logic [CIW-1:0]  win_idx;
    logic            unused_addr;

    // Region bit and window index fields.
    assign in_glob     = bus_addr[ADDR_W-1];
    assign win_idx     = bus_addr[ADDR_W-2:5];
    assign glob_hit    = in_glob && (win_idx == '0);
    assign glob_word   = bus_addr[4:2];
    assign chan_wr     = bus_wr && !in_glob;
    assign chan_off    = bus_addr[4:2];
    assign unused_addr = ^bus_addr[1:0];

    // One write enable per global register word.
    for (genvar g = 0; g < GREG_NUM; g++) begin : g_we
        assign greg_we[g] = glob_hit && bus_wr && (glob_word == 3'(g));
    end

    // One select per implemented channel window.
    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign chan_sel[i] = !in_glob && (win_idx == CIW'(i));
    end

endmodule

// File: rtl/dma_gc_pending.sv
// Module: per-channel interrupt-pending bits.
// A bit is set by a chain end that has the interrupt request set, by a halt or
// by an address fault. A write-back keeps only the bits written as one.
// A new event always wins over a clear in the same cycle.
// Assumes events are single-cycle pulses that are already synchronous to clk.
module dma_gc_pending #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_term,
    input  logic [NCH-1:0] ev_tie,
    input  logic [NCH-1:0] ev_halt,
    input  logic [NCH-1:0] ev_aerr,
    input  logic           wb_we,
    input  logic [NCH-1:0] wb_val,
    output logic [NCH-1:0] pend,
    output logic [NCH-1:0] ev_set
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Event that raises this channel's pending bit.
        assign ev_set[i] = (ev_term[i] && ev_tie[i]) || ev_halt[i] || ev_aerr[i];

        // Pending flop: write-back mask first, then the event sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (ev_set[i])
                pend[i] <= 1'b1;
            else if (wb_we)
                pend[i] <= pend[i] & wb_val[i];
        end

        // R4: a qualifying event is visible in the next cycle.
        assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[i] |=> pend[i]);

        // R5: a set bit only falls through a write-back that omits it.
        assert_hold_until_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !(wb_we && !wb_val[i])) |=> pend[i]);
    end

endmodule

// File: rtl/dma_gc_bitreg.sv
// Module: bit register with a load port and set and clear masks.
// Next value: (ld ? ld_val : q & ~clr) | set. So a load wins over a clear,
// and a set wins over both. It backs both the doorbell and the clock-enable words.
// Assumes the masks are single-cycle and synchronous to clk.
module dma_gc_bitreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);

    logic [W-1:0] base;

    // Value before the set mask is applied.
    assign base = ld ? ld_val : (q & ~clr);

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= base | set;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R7 (also R8): a set bit is present in the next cycle.
        assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);

        // R8 (also R7): a clear without a load or set takes effect.
        assert_clr_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ld && !set[i]) |=> !q[i]);
    end

endmodule

// File: rtl/dma_global_ctrl.sv
// Module: global control block for a group of NCH DMA channels.
// Holds the controller enable with sticky address-fault and halt summaries,
// the pending word, the doorbell word and the clock-enable word. It decodes the
// channel windows and drives one interrupt line.
// Assumes NCH <= 32 and that reads are combinational from bus_addr.
module dma_global_ctrl
    import dma_gc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NCH-1:0]        chan_sel,
    output logic                  chan_wr,
    output logic [2:0]            chan_off,
    input  logic [NCH*DATA_W-1:0] chan_rdata,
    input  logic [NCH-1:0]        ev_term,
    input  logic [NCH-1:0]        ev_tie,
    input  logic [NCH-1:0]        ev_halt,
    input  logic [NCH-1:0]        ev_aerr,
    input  logic [NCH-1:0]        db_ack,
    output logic [NCH-1:0]        db_req,
    output logic [NCH-1:0]        ch_clk_en,
    output logic                  irq
);

    localparam logic [NCH-1:0] NO_BITS = '0;

    logic                glob_hit;
    logic [2:0]          glob_word;
    logic [GREG_NUM-1:0] greg_we;
    logic [NCH-1:0]      wmask;
    logic [NCH-1:0]      pend;
    logic [NCH-1:0]      pend_set;
    logic                ctrl_en;
    logic                ctrl_aerr;
    logic                ctrl_halt;
    logic [DATA_W-1:0]   glob_rdata;
    logic [DATA_W-1:0]   chan_mux;
    logic                unused_wdata;

    assign wmask        = bus_wdata[NCH-1:0];
    assign unused_wdata = ^bus_wdata;

    dma_gc_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .glob_hit  (glob_hit),
        .glob_word (glob_word),
        .greg_we   (greg_we),
        .chan_sel  (chan_sel),
        .chan_wr   (chan_wr),
        .chan_off  (chan_off)
    );

    dma_gc_pending #(.NCH(NCH)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_term (ev_term),
        .ev_tie  (ev_tie),
        .ev_halt (ev_halt),
        .ev_aerr (ev_aerr),
        .wb_we   (greg_we[GREG_PEND]),
        .wb_val  (wmask),
        .pend    (pend),
        .ev_set  (pend_set)
    );

    dma_gc_bitreg #(.W(NCH)) u_door (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (greg_we[GREG_DOOR]),
        .ld_val (wmask),
        .clr    (db_ack),
        .set    (greg_we[GREG_DOOR_SET] ? wmask : NO_BITS),
        .q      (db_req)
    );

    dma_gc_bitreg #(.W(NCH)) u_clken (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (greg_we[GREG_CKEN]),
        .ld_val (wmask),
        .clr    (greg_we[GREG_CKEN_CLR] ? wmask : NO_BITS),
        .set    (greg_we[GREG_CKEN_SET] ? wmask : NO_BITS),
        .q      (ch_clk_en)
    );

    // Control register: enable is plain, summaries are sticky with event priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_aerr <= 1'b0;
            ctrl_halt <= 1'b0;
        end else begin
            if (greg_we[GREG_CTRL])
                ctrl_en <= bus_wdata[CTRL_EN_BIT];
            if (|ev_aerr)
                ctrl_aerr <= 1'b1;
            else if (greg_we[GREG_CTRL])
                ctrl_aerr <= ctrl_aerr & bus_wdata[CTRL_AERR_BIT];
            if (|ev_halt)
                ctrl_halt <= 1'b1;
            else if (greg_we[GREG_CTRL])
                ctrl_halt <= ctrl_halt & bus_wdata[CTRL_HALT_BIT];
        end
    end

    // Interrupt line: enabled OR of pending bits.
    assign irq = ctrl_en && (|pend);

    // Global register read mux.
    always_comb begin
        glob_rdata = '0;
        if (glob_hit) begin
            case (greg_e'(glob_word))
                GREG_CTRL: begin
                    glob_rdata[CTRL_EN_BIT]   = ctrl_en;
                    glob_rdata[CTRL_AERR_BIT] = ctrl_aerr;
                    glob_rdata[CTRL_HALT_BIT] = ctrl_halt;
                end
                GREG_PEND: glob_rdata = DATA_W'(pend);
                GREG_DOOR: glob_rdata = DATA_W'(db_req);
                GREG_CKEN: glob_rdata = DATA_W'(ch_clk_en);
                default:   glob_rdata = '0;
            endcase
        end
    end

    // Channel read mux: OR of the selected channel's word.
    always_comb begin
        chan_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan_sel[i])
                chan_mux = chan_mux | chan_rdata[i*DATA_W +: DATA_W];
        end
    end

    // Final read data.
    assign bus_rdata = glob_rdata | chan_mux;

    // R3: any address fault raises the summary in the next cycle.
    assert_aerr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_aerr) |=> ctrl_aerr);

    // R3: the halt summary holds unless the control register is written.
    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_halt && !greg_we[GREG_CTRL]) |=> ctrl_halt);

    // R6: with the controller enabled, a new event raises the interrupt.
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && (|pend_set) && !greg_we[GREG_CTRL]) |=> irq);

    // R6: while disabled, the interrupt stays low.
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !greg_we[GREG_CTRL]) |=> !irq);

    // R9: at most one channel window is selected.
    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));

    // R10: a global-region address never selects a channel.
    assert_glob_no_chan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[ADDR_W-1] |-> (chan_sel == '0 && !chan_wr));

endmodule

// File: tb/dma_global_ctrl_bench.sv
// Bench: directed corner cases followed by seeded random traffic.
// Expected values come from a bench-side model of the requirements.
module dma_global_ctrl_bench;

    localparam int NCH    = 8;
    localparam int ADDR_W = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NCH-1:0]      chan_sel;
    logic                chan_wr;
    logic [2:0]          chan_off;
    logic [NCH*32-1:0]   chan_rdata;
    logic [NCH-1:0]      ev_term = '0, ev_tie = '0, ev_halt = '0, ev_aerr = '0, db_ack = '0;
    logic [NCH-1:0]      db_req, ch_clk_en;
    logic                irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Bench model state.
    logic           m_en, m_ae, m_ht;
    logic [NCH-1:0] m_pend, m_db, m_clk;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NCH; i++)
            chan_rdata[i*32 +: 32] = 32'hC0DE_0000 | 32'(i);
    end

    dma_global_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dma_global_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_sel(chan_sel),
        .chan_wr(chan_wr), .chan_off(chan_off), .chan_rdata(chan_rdata),
        .ev_term(ev_term), .ev_tie(ev_tie), .ev_halt(ev_halt), .ev_aerr(ev_aerr),
        .db_ack(db_ack), .db_req(db_req), .ch_clk_en(ch_clk_en), .irq(irq)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a);
        if (a[11]) begin
            if (a[10:5] != 0) return 32'h0;
            case (a[4:2])
                3'd0:    return {28'h0, m_ht, m_ae, 1'b0, m_en};
                3'd1:    return 32'(m_pend);
                3'd2:    return 32'(m_db);
                3'd4:    return 32'(m_clk);
                default: return 32'h0;
            endcase
        end
        if (int'(a[10:5]) < NCH) return 32'hC0DE_0000 | 32'(a[10:5]);
        return 32'h0;
    endfunction

    function automatic logic [NCH-1:0] exp_sel(input logic [ADDR_W-1:0] a);
        logic [NCH-1:0] s = '0;
        if (!a[11] && int'(a[10:5]) < NCH) s[a[10:5]] = 1'b1;
        return s;
    endfunction

    function automatic string rd_tag(input logic [ADDR_W-1:0] a);
        if (!a[11]) return "R9";
        if (a[10:5] != 0) return "R10";
        case (a[4:2])
            3'd0:    return "R2/R3";
            3'd1:    return "R4/R5";
            3'd2:    return "R7";
            3'd4:    return "R8";
            default: return "R10";
        endcase
    endfunction

    // Model update at a clock edge, from the pre-edge stimulus.
    task automatic model_edge(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                              input logic [NCH-1:0] t, ti, h, ae, ak);
        logic ghit = w && a[11] && (a[10:5] == 0);
        logic [NCH-1:0] dm = d[NCH-1:0];
        logic [NCH-1:0] evs = (t & ti) | h | ae;
        logic [NCH-1:0] dbase;
        if (ghit && a[4:2] == 3'd1) m_pend = m_pend & dm;
        m_pend = m_pend | evs;
        if (ghit && a[4:2] == 3'd0) begin
            m_en = d[0];
            m_ae = m_ae & d[2];
            m_ht = m_ht & d[3];
        end
        if (|ae) m_ae = 1'b1;
        if (|h)  m_ht = 1'b1;
        dbase = (ghit && a[4:2] == 3'd2) ? dm : (m_db & ~ak);
        m_db = dbase | ((ghit && a[4:2] == 3'd3) ? dm : '0);
        if (ghit && a[4:2] == 3'd4) m_clk = dm;
        if (ghit && a[4:2] == 3'd6) m_clk = m_clk & ~dm;
        if (ghit && a[4:2] == 3'd5) m_clk = m_clk | dm;
    endtask

    // One bus cycle: drive after a falling edge, check reads, then outputs after the edge.
    task automatic step(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic [NCH-1:0] t, ti, h, ae, ak);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        ev_term = t; ev_tie = ti; ev_halt = h; ev_aerr = ae; db_ack = ak;
        #1;
        if (!w) begin
            check(bus_rdata, exp_rd(a), rd_tag(a));
            check(32'(chan_sel), 32'(exp_sel(a)), "R9");
            if (!a[11]) check(32'(chan_off), 32'(a[4:2]), "R9");
        end
        @(posedge clk);
        model_edge(w, a, d, t, ti, h, ae, ak);
        @(negedge clk);
        check(32'(irq), 32'(m_en && (|m_pend)), "R6");
        check(32'(db_req), 32'(m_db), "R7");
        check(32'(ch_clk_en), 32'(m_clk), "R8");
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        step(1'b0, a, 32'h0, '0, '0, '0, '0, '0);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0, '0, '0, '0, '0);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected at most 150000", cycles);
            summary();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        m_en = 0; m_ae = 0; m_ht = 0; m_pend = '0; m_db = '0; m_clk = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and output.
        check(32'(irq), 32'h0, "R1");
        check(32'(db_req), 32'h0, "R1");
        check(32'(ch_clk_en), 32'h0, "R1");
        rd(12'h800); rd(12'h804); rd(12'h808); rd(12'h810);

        // R2: only the enable bit is writable; summaries do not self-set.
        wr(12'h800, 32'hFFFF_FFFF); rd(12'h800);

        // R4: a chain end without its interrupt request is ignored.
        step(1'b0, 12'h804, 0, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00); rd(12'h804);
        // R4: a chain end with the request, then halt and address fault (R3 summaries).
        step(1'b0, 12'h804, 0, 8'h04, 8'h04, 8'h00, 8'h00, 8'h00); rd(12'h804);
        step(1'b0, 12'h800, 0, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00); rd(12'h800);
        step(1'b0, 12'h800, 0, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00); rd(12'h800); rd(12'h804);

        // R5: write-back keeps ones; an event beats a clear in the same cycle.
        wr(12'h804, 32'h21); rd(12'h804);
        step(1'b1, 12'h804, 32'h0, 8'h20, 8'h20, 8'h00, 8'h00, 8'h00); rd(12'h804);

        // R3: clearing the summaries while an address fault arrives.
        step(1'b1, 12'h800, 32'h1, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00); rd(12'h800);
        wr(12'h800, 32'h1); rd(12'h800);

        // R6: enable gates the interrupt; clearing pending drops it.
        wr(12'h800, 32'h0); wr(12'h800, 32'h1); wr(12'h804, 32'h0);

        // R7: doorbell set, set beating acknowledge, acknowledge, direct load.
        wr(12'h80C, 32'h81);
        step(1'b1, 12'h80C, 32'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
        step(1'b0, 12'h808, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80);
        wr(12'h808, 32'h3C); rd(12'h808);

        // R8: clock set, clear, direct load, and a clear with no ones.
        wr(12'h814, 32'h0F); wr(12'h818, 32'h05); wr(12'h810, 32'hF0);
        wr(12'h818, 32'h0); rd(12'h810);

        // R9: channel windows inside and beyond the channel count.
        rd(12'h000); rd(12'h0E4); rd(12'h100); rd(12'h7FC);

        // R10: unmapped global addresses read zero and ignore writes.
        wr(12'h820, 32'hFFFF_FFFF); wr(12'h81C, 32'hFFFF_FFFF);
        rd(12'h820); rd(12'h80C); rd(12'h814); rd(12'h818); rd(12'h81C);

        // Random traffic across all requirements.
        for (int k = 0; k < 3000; k++) begin
            logic w;
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            w = ($urandom % 2) == 0;
            if (w) begin
                int sel = $urandom % 8;
                a = (sel == 7) ? 12'h820 : 12'h800 + 12'(sel * 4);
                d = $urandom;
                if (sel == 0 && ($urandom % 4) != 0) d[0] = 1'b1;
            end else if (($urandom % 2) == 0) begin
                a = 12'h800 + 12'(($urandom % 8) * 4);
                if (($urandom % 8) == 0) a[7:5] = 3'b101;
            end else begin
                a = 12'($urandom % 2048) & 12'h7FC;
            end
            step(w, a, d,
                 NCH'($urandom & $urandom & $urandom),
                 NCH'($urandom),
                 NCH'($urandom & $urandom & $urandom & $urandom),
                 NCH'($urandom & $urandom & $urandom & $urandom),
                 NCH'($urandom & $urandom));
        end

        step(1'b0, 12'h800, 0, '0, '0, '0, '0, '0);
        summary();
    end

endmodule